// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Input Register

This block models the digital input stage of a data converter as synchronous logic. Two byte registers collect a 16-bit code: one takes the low byte and one takes the high byte. A 16-bit holding register sits behind them and feeds the converter core. All three registers are level-actuated. On every clock edge where its control is high, a register takes a new value. When its control is low, it keeps its value.

The holding register stays frozen while its strobe is low. Software can therefore load the next code byte by byte without disturbing the code the core is using. A single strobe then moves both bytes across together.

A parameter selects one of two bus wirings:
- **Narrow:** one 8-bit port feeds both bytes, and the enable decides which byte is written.
- **Wide:** a full 16-bit port is used. The two enables act as one tied signal. A second parameter models enables left unconnected; in that case both bytes take the bus on every clock.

Analog minimum pulse widths are reduced to cycle counts. A short-pulse flag is raised for each control line.

Top module: `dbuf_byte_loader`

## Requirements
- R1: While `load_cv` is sampled low, `word_q` keeps its value, whatever the byte registers and bus do.
- R2: On each clock edge where the low-byte enable is in force, the low byte register takes `bus_d[7:0]`.
- R3: On each clock edge where the high-byte enable is in force, the high byte register takes the top byte of the bus. That is `bus_d[7:0]` in narrow mode and `bus_d[15:8]` in wide mode. `word_q[15]` is the most significant bit, and the high byte occupies `word_q[15:8]`.
- R4: On each clock edge where `load_cv` is high, `word_q` takes {high byte, low byte` as they stood before that edge. A byte written on the same edge reaches `word_q` one clock later.
- R5: With `WIDE_BUS=0` the bus is 8 bits wide. `lo_en` and `hi_en` write their own byte independently from the same pins.
- R6: With `WIDE_BUS=1` and `EN_FLOAT=0`, a high level on either `lo_en` or `hi_en` loads both bytes.
- R7: With `WIDE_BUS=1` and `EN_FLOAT=1`, both bytes take the bus on every clock, regardless of the enables.
- R8: `short_flags` has bit 0 for `lo_en`, bit 1 for `hi_en` and bit 2 for `load_cv`. A bit goes high for exactly one clock, on the edge that first samples its control low, when the control was high for 1 to MIN-1 consecutive edges. MIN is `MIN_EN_CYC` for the enables and `MIN_LD_CYC` for the strobe. A pulse of MIN edges or more raises no flag.
- R9: A synchronous active-low reset clears both bytes, `word_q` and `short_flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_d | input | BUS_W (8 or 16) | Data pins |
| lo_en | input | 1 | Low-byte enable, level |
| hi_en | input | 1 | High-byte enable, level |
| load_cv | input | 1 | Holding-register strobe, level |
| word_q | output | 16 | Holding register, drives the converter core |
| short_flags | output | 3 | One-cycle short-pulse flags {load, high, low} |

## Verification
Three instances are driven from the same stimulus: narrow, wide with tied enables, and wide with floating enables. The same enable pattern therefore yields three different held words:
- A lone high-byte pulse puts `bus_d[7:0]` into the narrow high byte but loads both bytes in the tied wide instance.
- Byte writes with the strobe low check that the held word stays frozen.
- An enable raised together with the strobe separates the one-clock lag from an immediate pass-through.
- Pulses of 1, 2 and full length are applied to separate a missing short-pulse flag from a flag that appears when it should not.

A long mixed pattern is then compared against a behavioural model on every clock.

// File: rtl/dbuf_pkg.sv
// Package: shared definitions for the byte-loaded input register.
// Assumes: three control lines, indexed as below in the flag vector.
package dbuf_pkg;
    typedef enum logic [1:0] {
        CH_LO = 2'd0,
        CH_HI = 2'd1,
        CH_LD = 2'd2
    } ctl_ch_e;

    localparam int NUM_CTL = 3;
    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/byte_latch.sv
// Module: level-actuated register modelled synchronously.
// Takes d on every clock edge where take is high, holds otherwise.
// Assumes: synchronous active-low reset clears to zero.
module byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // follow d while take is high, keep value otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (take) begin
            q <= d;
        end
    end
endmodule

// File: rtl/width_mon.sv
// Module: minimum pulse-width monitor for one level control.
// Counts consecutive high samples (saturating at MIN_CYC) and, on the
// first low sample, emits a one-cycle flag if the run was short.
// Assumes: MIN_CYC >= 1; synchronous active-low reset.
module width_mon #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    output logic short_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

    logic [CW-1:0] run_len;

    // length of the current high run, saturating at the minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (ctl) begin
            if (run_len != MIN_V) begin
                run_len <= run_len + 1'b1;
            end
        end else begin
            run_len <= '0;
        end
    end

    // flag a run that ended before reaching the minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_o <= 1'b0;
        end else begin
            short_o <= !ctl && (run_len != '0) && (run_len < MIN_V);
        end
    end
endmodule

// File: rtl/dbuf_byte_loader.sv
// Module: double-buffered byte-loaded input register (top).
// Two byte registers fill from a narrow or wide bus; a holding register
// copies both when load_cv is high and freezes otherwise. Per-control
// monitors flag pulses shorter than the configured minimum.
// Assumes: EN_FLOAT only has effect when WIDE_BUS=1.
module dbuf_byte_loader
    import dbuf_pkg::*;
#(
    parameter int BYTE_W     = BYTE_BITS,
    parameter bit WIDE_BUS   = 1'b0,
    parameter bit EN_FLOAT   = 1'b0,
    parameter int MIN_EN_CYC = 4,
    parameter int MIN_LD_CYC = 3,
    localparam int BUS_W     = WIDE_BUS ? 2 * BYTE_W : BYTE_W,
    localparam int WORD_W    = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    bus_d,
    input  logic                lo_en,
    input  logic                hi_en,
    input  logic                load_cv,
    output logic [WORD_W-1:0]   word_q,
    output logic [NUM_CTL-1:0]  short_flags
);
    logic              take_lo;
    logic              take_hi;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic [NUM_CTL-1:0] ctl_vec;

    // enable decode chosen by the bus wiring
    generate
        if (WIDE_BUS && EN_FLOAT) begin : g_float
            assign take_lo = 1'b1;
            assign take_hi = 1'b1;
        end else if (WIDE_BUS) begin : g_tied
            assign take_lo = lo_en | hi_en;
            assign take_hi = lo_en | hi_en;
        end else begin : g_narrow
            assign take_lo = lo_en;
            assign take_hi = hi_en;
        end
    endgenerate

    // low byte always from the bottom of the bus
    byte_latch #(.W(BYTE_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .take(take_lo),
        .d(bus_d[BYTE_W-1:0]), .q(lo_byte)
    );

    // high byte from the top of the bus (same pins when narrow)
    byte_latch #(.W(BYTE_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .take(take_hi),
        .d(bus_d[BUS_W-1 -: BYTE_W]), .q(hi_byte)
    );

    // holding register copies both bytes while the strobe is high
    byte_latch #(.W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .take(load_cv),
        .d({hi_byte, lo_byte}), .q(word_q)
    );

    assign ctl_vec[CH_LO] = lo_en;
    assign ctl_vec[CH_HI] = hi_en;
    assign ctl_vec[CH_LD] = load_cv;

    // one width monitor per control, strobe uses its own minimum
    generate
        for (genvar g = 0; g < NUM_CTL; g++) begin : g_mon
            width_mon #(
                .MIN_CYC((g == int'(CH_LD)) ? MIN_LD_CYC : MIN_EN_CYC)
            ) u_mon (
                .clk(clk), .rst_n(rst_n), .ctl(ctl_vec[g]),
                .short_o(short_flags[g])
            );
        end
    endgenerate
endmodule

// File: rtl/dbuf_byte_loader_chk.sv
// Module: assertion checker bound to dbuf_byte_loader.
// Relates ports and byte-register state across clock edges.
// Assumes: same parameters as the bound instance.
module dbuf_byte_loader_chk #(
    parameter int BYTE_W   = 8,
    parameter bit WIDE_BUS = 1'b0,
    parameter bit EN_FLOAT = 1'b0,
    localparam int BUS_W   = WIDE_BUS ? 2 * BYTE_W : BYTE_W,
    localparam int WORD_W  = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  bus_d,
    input logic              lo_en,
    input logic              hi_en,
    input logic              load_cv,
    input logic [WORD_W-1:0] word_q,
    input logic [2:0]        short_flags,
    input logic [BYTE_W-1:0] lo_byte,
    input logic [BYTE_W-1:0] hi_byte
);
    logic want_lo;
    logic want_hi;
    assign want_lo = (WIDE_BUS && EN_FLOAT) || (WIDE_BUS ? (lo_en || hi_en) : lo_en);
    assign want_hi = (WIDE_BUS && EN_FLOAT) || (WIDE_BUS ? (lo_en || hi_en) : hi_en);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0 && short_flags == '0));

    // R1
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cv |=> $stable(word_q));

    // R4
    hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_cv |=> word_q == $past({hi_byte, lo_byte}));

    // R2
    lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        want_lo |=> lo_byte == $past(bus_d[BYTE_W-1:0]));

    // R3
    hi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        want_hi |=> hi_byte == $past(bus_d[BUS_W-1 -: BYTE_W]));

    // R2
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !want_lo |=> $stable(lo_byte));

    // R8
    flag_lo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_flags[0] |-> ($past(lo_en, 2) && !$past(lo_en)));

    // R8
    flag_hi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_flags[1] |-> ($past(hi_en, 2) && !$past(hi_en)));

    // R8
    flag_ld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_flags[2] |-> ($past(load_cv, 2) && !$past(load_cv)));
endmodule

bind dbuf_byte_loader dbuf_byte_loader_chk #(
    .BYTE_W(BYTE_W), .WIDE_BUS(WIDE_BUS), .EN_FLOAT(EN_FLOAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .lo_en(lo_en), .hi_en(hi_en),
    .load_cv(load_cv), .word_q(word_q), .short_flags(short_flags),
    .lo_byte(lo_byte), .hi_byte(hi_byte)
);

// File: tb/dbuf_byte_loader_bench.sv
// Bench: three instances (narrow, wide tied, wide floating) on shared
// stimulus, a behavioural reference model updated each clock, per-clock
// comparison plus directed checks at known cycles.
module dbuf_byte_loader_bench;
    localparam int CLK_T  = 10;
    localparam int MIN_EN = 4;
    localparam int MIN_LD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] d16 = '0;
    logic        lo_en = 1'b0;
    logic        hi_en = 1'b0;
    logic        load_cv = 1'b0;
    logic [15:0] w_word [3];
    logic [2:0]  w_fl [3];

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R9";

    always #(CLK_T / 2) clk = ~clk;

    dbuf_byte_loader #(.WIDE_BUS(1'b0), .EN_FLOAT(1'b0),
        .MIN_EN_CYC(MIN_EN), .MIN_LD_CYC(MIN_LD)) u_dbuf_byte_loader (
        .clk(clk), .rst_n(rst_n), .bus_d(d16[7:0]), .lo_en(lo_en), .hi_en(hi_en),
        .load_cv(load_cv), .word_q(w_word[0]), .short_flags(w_fl[0]));

    dbuf_byte_loader #(.WIDE_BUS(1'b1), .EN_FLOAT(1'b0),
        .MIN_EN_CYC(MIN_EN), .MIN_LD_CYC(MIN_LD)) u_dbuf_byte_loader_w (
        .clk(clk), .rst_n(rst_n), .bus_d(d16), .lo_en(lo_en), .hi_en(hi_en),
        .load_cv(load_cv), .word_q(w_word[1]), .short_flags(w_fl[1]));

    dbuf_byte_loader #(.WIDE_BUS(1'b1), .EN_FLOAT(1'b1),
        .MIN_EN_CYC(MIN_EN), .MIN_LD_CYC(MIN_LD)) u_dbuf_byte_loader_f (
        .clk(clk), .rst_n(rst_n), .bus_d(d16), .lo_en(lo_en), .hi_en(hi_en),
        .load_cv(load_cv), .word_q(w_word[2]), .short_flags(w_fl[2]));

    // reference model state: index 0 narrow, 1 wide tied, 2 wide floating
    logic [7:0]  m_lo [3];
    logic [7:0]  m_hi [3];
    logic [15:0] m_word [3];
    logic [2:0]  m_fl;
    int          m_run [3];

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_word[i] = '0; m_run[i] = 0;
        end
        m_fl = '0;
    end

    // behavioural model: advance on each rising edge from sampled inputs
    always @(posedge clk) begin
        logic [2:0] ctl;
        ctl = {load_cv, hi_en, lo_en};
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_lo[i] = '0; m_hi[i] = '0; m_word[i] = '0; m_run[i] = 0;
            end
            m_fl = '0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (load_cv) m_word[i] = {m_hi[i], m_lo[i]};
            end
            if (lo_en) m_lo[0] = d16[7:0];
            if (hi_en) m_hi[0] = d16[7:0];
            if (lo_en || hi_en) begin
                m_lo[1] = d16[7:0];
                m_hi[1] = d16[15:8];
            end
            m_lo[2] = d16[7:0];
            m_hi[2] = d16[15:8];
            for (int c = 0; c < 3; c++) begin
                int lim;
                lim = (c == 2) ? MIN_LD : MIN_EN;
                m_fl[c] = !ctl[c] && (m_run[c] > 0) && (m_run[c] < lim);
                m_run[c] = ctl[c] ? m_run[c] + 1 : 0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < 3; i++) begin
                chk(cur_tag, 32'(w_word[i]), 32'(m_word[i]));
                chk(cur_tag, 32'(w_fl[i]), 32'(m_fl));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R9 reset state
        tick(3);
        for (int i = 0; i < 3; i++) begin
            chk("R9 reset word", 32'(w_word[i]), 32'h0);
            chk("R9 reset flags", 32'(w_fl[i]), 32'h0);
        end
        rst_n = 1'b1;

        // R2 low byte, R1 hold frozen
        cur_tag = "R2 R1";
        d16 = 16'h77A5; lo_en = 1'b1; tick(4); lo_en = 1'b0; tick(1);
        chk("R1 narrow frozen", 32'(w_word[0]), 32'h0);
        chk("R1 wide frozen", 32'(w_word[1]), 32'h0);
        chk("R8 full enable no flag", 32'(w_fl[0]), 32'h0);

        // R3 high byte, then R4 transfer
        cur_tag = "R3 R4";
        d16 = 16'h003C; hi_en = 1'b1; tick(4); hi_en = 1'b0; tick(1);
        load_cv = 1'b1; tick(3); load_cv = 1'b0; tick(1);
        chk("R4 narrow word", 32'(w_word[0]), 32'h3CA5);
        chk("R6 wide tied word", 32'(w_word[1]), 32'h003C);
        chk("R7 floating word", 32'(w_word[2]), 32'h003C);

        // R1 byte change with strobe low
        cur_tag = "R1";
        d16 = 16'h5A5A; lo_en = 1'b1; tick(4); lo_en = 1'b0; tick(2);
        chk("R1 narrow held", 32'(w_word[0]), 32'h3CA5);

        // R4 enable and strobe together: one-clock lag
        cur_tag = "R4 R8";
        d16 = 16'h9911; lo_en = 1'b1; load_cv = 1'b1; tick(1);
        chk("R4 same-edge old byte", 32'(w_word[0]), 32'h3C5A);
        tick(1);
        chk("R4 next-edge new byte", 32'(w_word[0]), 32'h3C11);
        lo_en = 1'b0; tick(1);
        chk("R8 short low enable", 32'(w_fl[0]), 32'b001);
        load_cv = 1'b0; tick(1);
        chk("R8 flag one cycle, strobe full", 32'(w_fl[0]), 32'b000);

        // R8 short strobe
        load_cv = 1'b1; tick(1); load_cv = 1'b0; tick(1);
        chk("R8 short strobe", 32'(w_fl[0]), 32'b100);

        // R7 floating enables follow bus without any enable
        cur_tag = "R7";
        d16 = 16'hBEEF; load_cv = 1'b1; tick(3); load_cv = 1'b0; tick(1);
        chk("R7 floating follows bus", 32'(w_word[2]), 32'hBEEF);
        chk("R4 narrow bytes unchanged", 32'(w_word[0]), 32'h3C11);

        // R5 narrow vs R6 tied: lone high-byte pulse
        cur_tag = "R5 R6";
        d16 = 16'h1234; hi_en = 1'b1; tick(4); hi_en = 1'b0; tick(1);
        load_cv = 1'b1; tick(3); load_cv = 1'b0; tick(1);
        chk("R6 tied loads both", 32'(w_word[1]), 32'h1234);
        chk("R5 narrow high from low pins", 32'(w_word[0]), 32'h3411);

        // R9 reset mid-run
        cur_tag = "R9";
        rst_n = 1'b0; tick(1);
        for (int i = 0; i < 3; i++) begin
            chk("R9 mid reset word", 32'(w_word[i]), 32'h0);
        end
        rst_n = 1'b1;

        // mixed pattern, compared each clock
        cur_tag = "R2 R3 R4 R8 mixed";
        for (int i = 0; i < 80; i++) begin
            d16 = 16'(i * 16'h2B17 + 16'h00C3);
            lo_en = i[0] ^ i[3];
            hi_en = i[1] & ~i[4];
            load_cv = i[2] | i[5];
            tick(1);
        end
        lo_en = 1'b0; hi_en = 1'b0; load_cv = 1'b0; tick(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule